// File: doc/BRIEF.md
# OTP Programming Interface Controller

This block is the device-side controller that an external programmer talks to when it writes or verifies a one-time-programmable code store. All control inputs arrive as slow pin levels. They pass through a synchronizer and are then edge-detected in the core clock domain. A fixed pin sequence puts the block into programming mode. Once there, the programmer picks an access kind on two select lines and qualifies it with an address strobe. That strobe also captures the upper address byte, which then serves as a page address for any number of later accesses. Write and read strobes move bytes over an 8-bit data port.

The block turns each accepted write strobe into a single-cycle write toward an on-chip memory, and each read strobe into a registered read with an output enable for the data port. It also holds two lock bits that can only be cleared, and it answers reads of three fixed identification bytes.

The memory side has no back-pressure. A write is accepted in the cycle `mem_we_o` is high. Read data is expected on `mem_rdata_i` one cycle after `mem_addr_o` settles, and the block holds the address steady for as long as the read strobe stays low. The control pins are plain levels, not a stream interface, so no valid/ready handshake applies.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After system reset, `mem_we_o`, `mem_re_o` and `data_oe_o` are 0, `data_out_o` is 0, the lock bits are 2'b11, and no access is accepted until programming mode has been entered.
- R2: Programming mode is entered only by this sequence. First, with reset pin, store-enable, address strobe, write strobe, select bit 1 and the voltage pin all low, and mode-select, read strobe and select bit 0 all high, the block arms. Then, at the falling edge of mode-select, the write strobe and voltage pin must both still be low. After that, the write strobe must rise. If either pin is high at the falling edge, the block returns to idle and ignores all accesses.
- R3: While in programming mode, raising mode-select, the reset pin or store-enable leaves the mode, and all later accesses are ignored until the sequence of R2 is repeated.
- R4: The access kind is taken from `acc_sel_i` at the rising edge of the address strobe. The upper address byte is taken from `addr_port_i` at its falling edge and is reused for every later access until the strobe pulses again. The lower byte is taken live from `addr_port_i`.
- R5: With access kind 2'b11, programming voltage valid and the read strobe high, each falling edge of the write strobe produces exactly one single-cycle `mem_we_o`, with `mem_addr_o` = {upper byte, lower byte} and `mem_wdata_o` = port data.
- R6: A write strobe with the programming-voltage flag low, or with the read strobe held low, produces no memory write.
- R7: If `acc_sel_i` differs from the kind latched at the last address strobe, accesses are ignored (no write, port not driven) until the strobe pulses again. Access kind 2'b01 is the one exception.
- R8: With `acc_sel_i` = 2'b01, a read returns C5h, 95h or 01h at lower addresses FCh, FDh and FEh, and 00h at every other address. No address-strobe pulse is needed. A write strobe in this kind changes nothing.
- R9: With access kind 2'b10, a programming write clears each lock bit whose data bit (D1, D0) is 0 and never sets a bit. A read returns {6'b111111, lock[1:0]}.
- R10: `data_oe_o` is 1 only while the read strobe is low in programming mode with a valid read kind and the voltage pin at logic high or programming level. It drops within three cycles after the read strobe rises, and it is never 1 in the same cycle as `mem_we_o`.
- R11: Access kind 2'b00 is reserved. Its reads and writes have no effect and leave the data port released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_pin_i | input | 1 | Device reset pin level, must stay low in programming mode |
| pstore_en_i | input | 1 | Program-store enable pin level, must stay low |
| mode_sel_i | input | 1 | Mode-select strobe; its falling edge completes entry |
| addr_strobe_i | input | 1 | Address strobe; rising edge latches access kind, falling edge latches upper address |
| acc_sel_i | input | 2 | Access kind: 00 reserved, 01 identification bytes, 10 lock bits, 11 memory byte |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| vpin_high_i | input | 1 | Voltage pin at logic-high level |
| vpp_ok_i | input | 1 | Voltage pin at programming level |
| addr_port_i | input | 8 | Multiplexed address port |
| data_in_i | input | 8 | Data port, inbound half |
| data_out_o | output | 8 | Data port, outbound half |
| data_oe_o | output | 1 | Drive enable for the data port |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write, one cycle per byte |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
The bench attacks the entry sequence from both sides. It tries a write strobe that rises before the mode-select edge and a voltage pin that is already high at that edge. A design that latched the pins at the wrong moment would then accept writes. The bench crosses a page boundary, with several writes per page and one address-strobe pulse per page, and reads everything back at logic-high voltage. A design that re-sampled the upper byte live, or missed the falling-edge capture, would return wrong bytes. The bench also switches access kind without a new strobe, sweeps all 256 identification addresses, tries to set lock bits back to 1, and drops the read strobe during a write. Each of these exposes a missing qualification, which shows up as a stray write, a driven port or a reopened lock bit.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [1:0] {
    ACC_RSVD = 2'b00,
    ACC_VER  = 2'b01,
    ACC_LOCK = 2'b10,
    ACC_MEM  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LATCHED,
    ST_ACTIVE
  } entry_st_e;

  localparam int VER_N = 3;
  localparam logic [7:0] VER_VAL [VER_N] = '{8'hC5, 8'h95, 8'h01};

endpackage

// File: rtl/otp_pin_sync.sv
module otp_pin_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[i] <= RST_VAL;
        else        pipe[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[i] <= RST_VAL;
        else        pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/otp_entry_fsm.sv
module otp_entry_fsm
  import otp_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin_s,
  input  logic       pstore_s,
  input  logic       mode_sel_s,
  input  logic       ale_s,
  input  logic       wr_n_s,
  input  logic       rd_n_s,
  input  logic [1:0] acc_s,
  input  logic       vpin_s,
  output logic       active_o
);
  entry_st_e st, st_nx;
  logic msel_p;
  logic leave, pre_ok, msel_fall;

  assign leave     = rst_pin_s | pstore_s;
  assign msel_fall = msel_p & ~mode_sel_s;
  assign pre_ok    = !rst_pin_s && !pstore_s && mode_sel_s && !wr_n_s && !ale_s &&
                     (acc_s == 2'b01) && !vpin_s && rd_n_s;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (pre_ok) st_nx = ST_ARMED;
      ST_ARMED:   if (leave) st_nx = ST_IDLE;
                  else if (msel_fall) st_nx = (!wr_n_s && !vpin_s) ? ST_LATCHED : ST_IDLE;
      ST_LATCHED: if (leave || mode_sel_s) st_nx = ST_IDLE;
                  else if (wr_n_s) st_nx = ST_ACTIVE;
      ST_ACTIVE:  if (leave || mode_sel_s) st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_IDLE;
      msel_p <= 1'b0;
    end else begin
      st     <= st_nx;
      msel_p <= mode_sel_s;
    end

  assign active_o = (st == ST_ACTIVE);

  // R2: the active state is reachable only through the latched step
  assert_entry_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE) |-> ($past(st) == ST_ACTIVE || $past(st) == ST_LATCHED));

  // R3: mode-select high while active forces idle
  assert_exit_on_msel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && mode_sel_s) |=> (st == ST_IDLE));
endmodule

// File: rtl/otp_lock_store.sv
module otp_lock_store #(
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LOCK_W-1:0] wr_bits,
  output logic [LOCK_W-1:0] lock_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     lock_o <= '1;
    else if (wr_en) lock_o <= lock_o & wr_bits;

  // R9: a lock bit never returns from 0 to 1
  assert_lock_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_o & ~$past(lock_o)) == '0));
endmodule

// File: rtl/otp_access_unit.sv
module otp_access_unit
  import otp_prog_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LOCK_W   = 2,
  parameter int VER_BASE = 252
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                ale_s,
  input  logic                wr_n_s,
  input  logic                rd_n_s,
  input  logic [1:0]          acc_s,
  input  logic                vpin_s,
  input  logic                vpp_s,
  input  logic [PORT_W-1:0]   addr_port_i,
  input  logic [DATA_W-1:0]   data_in_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic [LOCK_W-1:0]   lock_i,
  output logic                lock_wr_o,
  output logic [DATA_W-1:0]   data_out_o,
  output logic                data_oe_o,
  output logic [2*PORT_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_we_o,
  output logic                mem_re_o
);
  localparam int FILL_W = DATA_W - LOCK_W;

  acc_kind_e           kind_q, rkind_q, acc_k;
  logic                kind_ok_q, ale_p, wr_p;
  logic [PORT_W-1:0]   hi_q;
  logic [2*PORT_W-1:0] addr_q;
  logic [DATA_W-1:0]   wdata_q, ver_byte;
  logic                we_q, oe_q;
  logic                ale_rise, ale_fall, wr_fall, sel_ok, prog_ok, rd_go, mem_wr_d;

  assign acc_k    = acc_kind_e'(acc_s);
  assign ale_rise = ale_s & ~ale_p;
  assign ale_fall = ~ale_s & ale_p;
  assign wr_fall  = ~wr_n_s & wr_p;

  // kind and page latch, cleared whenever programming mode is not held
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kind_q    <= ACC_RSVD;
      kind_ok_q <= 1'b0;
      hi_q      <= '0;
    end else if (!active) begin
      kind_ok_q <= 1'b0;
      hi_q      <= '0;
    end else begin
      if (ale_rise) begin
        kind_q    <= acc_k;
        kind_ok_q <= 1'b1;
      end
      if (ale_fall) hi_q <= addr_port_i;
    end

  assign sel_ok = active && ((acc_k == ACC_VER) ||
                  (kind_ok_q && kind_q == acc_k && acc_k != ACC_RSVD));

  assign prog_ok   = sel_ok && wr_fall && rd_n_s && vpp_s;
  assign mem_wr_d  = prog_ok && (acc_k == ACC_MEM);
  assign lock_wr_o = prog_ok && (acc_k == ACC_LOCK);
  assign rd_go     = sel_ok && !rd_n_s && wr_n_s && (vpin_s || vpp_s) && (acc_k != ACC_RSVD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ale_p   <= 1'b0;
      wr_p    <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      rkind_q <= ACC_RSVD;
    end else begin
      ale_p   <= ale_s;
      wr_p    <= wr_n_s;
      addr_q  <= {hi_q, addr_port_i};
      wdata_q <= data_in_i;
      we_q    <= mem_wr_d;
      oe_q    <= rd_go;
      rkind_q <= acc_k;
    end

  always_comb begin
    ver_byte = '0;
    for (int k = 0; k < VER_N; k++)
      if (addr_q[PORT_W-1:0] == PORT_W'(VER_BASE + k)) ver_byte = DATA_W'(VER_VAL[k]);
  end

  always_comb begin
    data_out_o = '0;
    if (oe_q) begin
      unique case (rkind_q)
        ACC_MEM:  data_out_o = mem_rdata_i;
        ACC_VER:  data_out_o = ver_byte;
        ACC_LOCK: data_out_o = {{FILL_W{1'b1}}, lock_i};
        default:  data_out_o = '0;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = we_q;
  assign mem_re_o    = oe_q && (rkind_q == ACC_MEM);
  assign data_oe_o   = oe_q;

  // R5: one write strobe yields a single-cycle write
  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  // R10: port drive and memory write never coincide
  assert_no_oe_with_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && data_oe_o));

  // R2: a memory write follows a cycle spent in programming mode
  assert_we_needs_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(active));

  // R4: the page byte holds between strobe falling edges while active
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ale_fall) |=> (!active || $stable(hi_q)));
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LOCK_W   = 2,
  parameter int SYNC_N   = 2,
  parameter int VER_BASE = 252
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_pin_i,
  input  logic                pstore_en_i,
  input  logic                mode_sel_i,
  input  logic                addr_strobe_i,
  input  logic [1:0]          acc_sel_i,
  input  logic                wr_n_i,
  input  logic                rd_n_i,
  input  logic                vpin_high_i,
  input  logic                vpp_ok_i,
  input  logic [PORT_W-1:0]   addr_port_i,
  input  logic [DATA_W-1:0]   data_in_i,
  output logic [DATA_W-1:0]   data_out_o,
  output logic                data_oe_o,
  output logic [2*PORT_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_we_o,
  output logic                mem_re_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int CTRL_W = 10;
  localparam logic [CTRL_W-1:0] CTRL_RST = 10'b11_0_0_1_1_00_0_0;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic              rst_pin_s, pstore_s, msel_s, ale_s, wr_s, rd_s, vpin_s, vpp_s;
  logic [1:0]        acc_s;
  logic              active, lock_wr;
  logic [LOCK_W-1:0] lock_bits;

  assign ctrl_raw = {rst_pin_i, pstore_en_i, mode_sel_i, addr_strobe_i,
                     wr_n_i, rd_n_i, acc_sel_i, vpin_high_i, vpp_ok_i};

  otp_pin_sync #(.W(CTRL_W), .STAGES(SYNC_N), .RST_VAL(CTRL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s));

  assign {rst_pin_s, pstore_s, msel_s, ale_s, wr_s, rd_s, acc_s, vpin_s, vpp_s} = ctrl_s;

  otp_entry_fsm u_entry (
    .clk(clk), .rst_n(rst_n), .rst_pin_s(rst_pin_s), .pstore_s(pstore_s),
    .mode_sel_s(msel_s), .ale_s(ale_s), .wr_n_s(wr_s), .rd_n_s(rd_s),
    .acc_s(acc_s), .vpin_s(vpin_s), .active_o(active));

  otp_lock_store #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_wr),
    .wr_bits(data_in_i[LOCK_W-1:0]), .lock_o(lock_bits));

  otp_access_unit #(.PORT_W(PORT_W), .DATA_W(DATA_W), .LOCK_W(LOCK_W),
                    .VER_BASE(VER_BASE)) u_access (
    .clk(clk), .rst_n(rst_n), .active(active), .ale_s(ale_s), .wr_n_s(wr_s),
    .rd_n_s(rd_s), .acc_s(acc_s), .vpin_s(vpin_s), .vpp_s(vpp_s),
    .addr_port_i(addr_port_i), .data_in_i(data_in_i), .mem_rdata_i(mem_rdata_i),
    .lock_i(lock_bits), .lock_wr_o(lock_wr), .data_out_o(data_out_o),
    .data_oe_o(data_oe_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o));

  // R6: no memory write unless the programming level was seen
  assert_we_needs_vpp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(vpp_s));

  // R1: memory read enable only together with port drive
  assert_re_with_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> data_oe_o);
endmodule

// File: tb/otp_prog_ctrl_test.sv
`timescale 1ns/1ps
module otp_prog_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, rst_pin, pstore, mode_sel, ale, wr_n, rd_n, vpin, vpp;
  logic [1:0]  acc;
  logic [7:0]  addr_port, data_in, data_out, mem_wdata;
  logic        data_oe, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;

  otp_prog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin), .pstore_en_i(pstore),
    .mode_sel_i(mode_sel), .addr_strobe_i(ale), .acc_sel_i(acc), .wr_n_i(wr_n),
    .rd_n_i(rd_n), .vpin_high_i(vpin), .vpp_ok_i(vpp), .addr_port_i(addr_port),
    .data_in_i(data_in), .data_out_o(data_out), .data_oe_o(data_oe),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_rdata_i(mem_rdata));

  logic [7:0]  mem [int];
  int          wcount = 0;
  logic [15:0] last_a = '0;
  logic [7:0]  last_d = '0;
  int          tests = 0, fails = 0, cyc = 0;
  logic        done = 1'b0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wcount = wcount + 1;
      last_a = mem_addr;
      last_d = mem_wdata;
    end
    mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000 && !done) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] hi, input logic [7:0] lo);
    return (lo * 8'd7) ^ hi ^ 8'h3C;
  endfunction

  function automatic logic [7:0] ver_exp(input logic [7:0] lo);
    case (lo)
      8'hFC:   return 8'hC5;
      8'hFD:   return 8'h95;
      8'hFE:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic arm_pins();
    rst_pin = 0; pstore = 0; mode_sel = 1; wr_n = 0; ale = 0;
    acc = 2'b01; vpin = 0; vpp = 0; rd_n = 1;
    tick(5);
  endtask

  task automatic enter_prog();
    arm_pins();
    mode_sel = 0; tick(5);
    wr_n = 1; tick(5);
    vpin = 1; tick(2);
  endtask

  task automatic latch(input logic [1:0] k, input logic [7:0] hi);
    acc = k; addr_port = hi; tick(2);
    ale = 1; tick(5);
    ale = 0; tick(5);
  endtask

  task automatic do_write(input logic [7:0] lo, input logic [7:0] d);
    addr_port = lo; data_in = d; tick(2);
    wr_n = 0; tick(6);
    wr_n = 1; tick(4);
  endtask

  task automatic do_read(input logic [7:0] lo, output logic [7:0] d, output logic oe);
    addr_port = lo; tick(2);
    rd_n = 0; tick(7);
    d = data_out; oe = data_oe;
    rd_n = 1; tick(4);
  endtask

  initial begin
    logic [7:0] rd;
    logic       oe;
    int         w0;
    logic [1:0] lock_exp;

    rst_n = 0; rst_pin = 1; pstore = 1; mode_sel = 0; ale = 0; acc = 0;
    wr_n = 1; rd_n = 1; vpin = 0; vpp = 0; addr_port = 0; data_in = 0;
    tick(5);
    chk("R1 reset oe", data_oe, 0);
    chk("R1 reset we", mem_we, 0);
    chk("R1 reset dout", data_out, 0);
    rst_n = 1; tick(5);

    // R2: no entry at all
    latch(2'b11, 8'h12); vpp = 1;
    do_write(8'h01, 8'hAA);
    chk("R2 write before entry", wcount, 0);
    do_read(8'h01, rd, oe);
    chk("R2 read before entry oe", oe, 0);

    // R2: write strobe high at mode-select fall
    arm_pins(); wr_n = 1; tick(5); mode_sel = 0; tick(5);
    latch(2'b11, 8'h12); vpp = 1; vpin = 1;
    do_write(8'h02, 8'hAB);
    chk("R2 bad entry wr high", wcount, 0);

    // R2: voltage pin high at mode-select fall
    arm_pins(); vpin = 1; tick(5); mode_sel = 0; tick(5); wr_n = 1; tick(5);
    latch(2'b11, 8'h12); vpp = 1;
    do_write(8'h03, 8'hAC);
    chk("R2 bad entry vpin high", wcount, 0);
    do_read(8'h03, rd, oe);
    chk("R2 bad entry read oe", oe, 0);

    // R4/R5: page writes
    enter_prog();
    latch(2'b11, 8'h12); vpp = 1;
    for (int i = 0; i < 16; i++) begin
      w0 = wcount;
      do_write(8'(i), pat(8'h12, 8'(i)));
      chk("R5 one write per strobe", wcount, w0 + 1);
      chk("R4 write address", last_a, {8'h12, 8'(i)});
      chk("R5 write data", last_d, pat(8'h12, 8'(i)));
    end
    latch(2'b11, 8'h03);
    for (int i = 253; i < 256; i++) do_write(8'(i), pat(8'h03, 8'(i)));
    latch(2'b11, 8'h04);
    do_write(8'h00, pat(8'h04, 8'h00));
    chk("R4 page 04 address", last_a, 16'h0400);
    chk("R5 total writes", wcount, 20);

    // R4: read back at logic-high voltage
    vpp = 0;
    do_read(8'h00, rd, oe);
    chk("R4 readback 0400", rd, pat(8'h04, 8'h00));
    chk("R10 oe during read", oe, 1);
    chk("R10 oe released", data_oe, 0);
    latch(2'b11, 8'h03);
    for (int i = 253; i < 256; i++) begin
      do_read(8'(i), rd, oe);
      chk("R4 readback page 03", rd, pat(8'h03, 8'(i)));
    end
    latch(2'b11, 8'h12);
    for (int i = 0; i < 16; i++) begin
      do_read(8'(i), rd, oe);
      chk("R4 readback page 12", rd, pat(8'h12, 8'(i)));
    end

    // R6: missing programming level, read strobe low
    w0 = wcount;
    do_write(8'h05, 8'h00);
    chk("R6 no vpp no write", wcount, w0);
    vpp = 1; rd_n = 0; tick(2);
    do_write(8'h06, 8'h00);
    rd_n = 1; tick(4);
    chk("R6 rd low no write", wcount, w0);

    // R8: identification sweep, no strobe
    acc = 2'b01; vpp = 0; tick(2);
    for (int i = 0; i < 256; i++) begin
      do_read(8'(i), rd, oe);
      chk("R8 id byte", {oe, rd}, {1'b1, ver_exp(8'(i))});
    end
    vpp = 1;
    do_write(8'hFC, 8'h00);
    chk("R8 id write ignored", wcount, w0);
    do_read(8'hFC, rd, oe);
    chk("R8 id unchanged", rd, 8'hC5);

    // R7: kind change without strobe
    acc = 2'b10; tick(2);
    do_write(8'h00, 8'hFC);
    do_read(8'h00, rd, oe);
    chk("R7 mismatched kind oe", oe, 0);

    // R9: lock bits
    latch(2'b10, 8'h00);
    lock_exp = 2'b11;
    do_read(8'h00, rd, oe);
    chk("R9 lock after ignored write", rd, {6'h3F, lock_exp});
    for (int i = 0; i < 4; i++) begin
      logic [7:0] d;
      d = 8'hF0 | 8'(3 - i);
      do_write(8'h00, d);
      lock_exp = lock_exp & d[1:0];
      do_read(8'h00, rd, oe);
      chk("R9 lock clear only", rd, {6'h3F, lock_exp});
    end
    chk("R9 lock no mem write", wcount, w0);

    acc = 2'b11; tick(2);
    do_write(8'h07, 8'h11);
    chk("R7 write with stale kind", wcount, w0);

    // R11: reserved kind
    latch(2'b00, 8'h12);
    do_write(8'h08, 8'h22);
    chk("R11 reserved write", wcount, w0);
    do_read(8'h08, rd, oe);
    chk("R11 reserved read oe", oe, 0);

    // R3: leave mode
    mode_sel = 1; tick(5);
    latch(2'b11, 8'h12);
    do_write(8'h09, 8'h33);
    chk("R3 write after exit", wcount, w0);
    do_read(8'h00, rd, oe);
    chk("R3 read after exit oe", oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule